// File: doc/BRIEF.md
# Serial Programming-Mode Entry Sequencer

This block is the master side of a three-wire serial link plus a reset wire. It places a target microcontroller into its serial programming mode. A start request makes it hold the target reset low with the serial clock parked low. It then waits a settling interval, counted in system clocks, and shifts out a four-byte entry frame. The target echoes each byte one slot late, so the byte received while the third frame byte goes out must equal the second frame byte. A match proves that the target is synchronised.

When the echo is wrong, the block releases the target reset for a short pulse and pulls it low again. It waits the full settling interval and sends a complete new frame. It stops with a done flag, leaving the target in reset and ready for commands, or with a fail flag once the allowed number of attempts is used up. The low and high halves of the serial clock are set at run time in system clocks, so that the target's minimum clock phase times can be met whatever its own oscillator speed.

Top module: `isp_entry_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are `tgt_rst_n`=1, `sck`=0, `mosi`=0, `done`=0 and `fail`=0.
- R2: A start that is accepted drives `tgt_rst_n` low at the next clock edge. `sck` stays low until at least SETTLE_CYC = CLK_HZ*SETTLE_US/1e6 clocks after each fall of `tgt_rst_n`. `sck` is never high while `tgt_rst_n` is high.
- R3: Each attempt shifts exactly the bytes 0xAC, 0x53, 0x00, 0x00, in that order, most significant bit first. The target samples `mosi` on each rising `sck` edge, and `mosi` does not change while `sck` is high.
- R4: Every high phase of `sck` lasts `sck_hi_div`+1 clocks. Every low phase between two bits of the same byte lasts `sck_lo_div`+1 clocks.
- R5: `miso` is sampled on each rising `sck` edge, most significant bit first. An attempt counts as synchronised only when the byte captured during the third frame byte equals 0x53.
- R6: After a synchronised attempt, `done` goes to 1 and stays there, with `tgt_rst_n` held at 0 and `sck` held at 0, until the next start.
- R7: After an unsynchronised attempt with attempts left, `tgt_rst_n` goes high for exactly PULSE_CYC clocks. It then returns low and a new settling wait and a new full frame follow.
- R8: All four bytes of a frame are shifted even when the echo has already failed, so the target receives 4 bytes per attempt and no more.
- R9: When `max_tries` attempts have all failed, `fail` goes to 1, `done` stays 0 and `tgt_rst_n` is released high, with no further `sck` edges. A `max_tries` value of 0 behaves like 1.
- R10: A start that arrives while the sequence is running (neither idle, done nor failed) has no effect.
- R11: `done` and `fail` are never both 1, and both read 0 one clock after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin the entry sequence |
| max_tries | input | RETRY_W | Attempt limit (0 acts as 1) |
| sck_lo_div | input | DIV_W | Serial clock low phase length minus one, in clocks |
| sck_hi_div | input | DIV_W | Serial clock high phase length minus one, in clocks |
| miso | input | 1 | Serial data from the target |
| tgt_rst_n | output | 1 | Active-low reset driven to the target |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| done | output | 1 | Target synchronised and left in programming mode |
| fail | output | 1 | Attempt limit exhausted without synchronisation |

## Verification
A corrupted bit counter or frame index shows up within the first frame. The target model then receives a byte that differs from 0xAC/0x53/0x00/0x00, or a fifth byte, and the scoreboard sees it at the next byte boundary. A fault in the settle or pulse timer shows as the wrong reset pulse width, or as an early clock edge after `tgt_rst_n` falls, measured at the first rising `sck` of the attempt. A wrong echo capture or attempt count only appears at the end of a frame, as a `done`/`fail` outcome or a frame count that does not match the number of corrupted echoes injected.

// File: rtl/isp_pkg.sv
package isp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_LOAD,
      ST_XFER,
      ST_PULSE,
      ST_DONE,
      ST_FAIL
   } seq_state_e;

   localparam logic [7:0] ENTRY_OP  = 8'hAC;
   localparam logic [7:0] SYNC_BYTE = 8'h53;
   localparam logic [7:0] PAD_BYTE  = 8'h00;
   localparam int         FRAME_LEN = 4;
   localparam logic [1:0] ECHO_SLOT = 2'd2;
   localparam logic [1:0] LAST_SLOT = 2'(FRAME_LEN - 1);

   function automatic logic [7:0] frame_byte(input logic [1:0] idx);
      case (idx)
         2'd0:    frame_byte = ENTRY_OP;
         2'd1:    frame_byte = SYNC_BYTE;
         default: frame_byte = PAD_BYTE;
      endcase
   endfunction

endpackage

// File: rtl/isp_tick_timer.sv
module isp_tick_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= ld_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/isp_spi_shift.sv
module isp_spi_shift #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [7:0]       tx_byte,
   input  logic [DIV_W-1:0] lo_div,
   input  logic [DIV_W-1:0] hi_div,
   input  logic             miso,
   output logic             sck,
   output logic             mosi,
   output logic [7:0]       rx_byte,
   output logic             fin
);

   logic             active_q;
   logic             phase_q;
   logic             fin_q;
   logic [2:0]       bit_q;
   logic [DIV_W-1:0] cnt_q;
   logic [7:0]       tx_q;
   logic [7:0]       rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         phase_q  <= 1'b0;
         fin_q    <= 1'b0;
         bit_q    <= '0;
         cnt_q    <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
      end else begin
         fin_q <= 1'b0;
         if (go) begin
            active_q <= 1'b1;
            phase_q  <= 1'b0;
            bit_q    <= '0;
            cnt_q    <= lo_div;
            tx_q     <= tx_byte;
         end else if (active_q) begin
            if (cnt_q != '0) begin
               cnt_q <= cnt_q - DIV_W'(1);
            end else if (!phase_q) begin
               // rising edge: capture the target bit, msb first
               phase_q <= 1'b1;
               cnt_q   <= hi_div;
               rx_q    <= {rx_q[6:0], miso};
            end else begin
               // falling edge: next bit presented during the low phase
               phase_q <= 1'b0;
               if (bit_q == 3'd7) begin
                  active_q <= 1'b0;
                  fin_q    <= 1'b1;
               end else begin
                  bit_q <= bit_q + 3'd1;
                  tx_q  <= {tx_q[6:0], 1'b0};
                  cnt_q <= lo_div;
               end
            end
         end
      end
   end

   assign sck     = phase_q;
   assign mosi    = active_q & tx_q[7];
   assign rx_byte = rx_q;
   assign fin     = fin_q;

endmodule

// File: rtl/isp_entry_seq.sv
module isp_entry_seq #(
   parameter int unsigned CLK_HZ    = 200_000_000,
   parameter int unsigned SETTLE_US = 20_000,
   parameter int unsigned PULSE_CYC = 64,
   parameter int          DIV_W     = 8,
   parameter int          RETRY_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [RETRY_W-1:0] max_tries,
   input  logic [DIV_W-1:0]   sck_lo_div,
   input  logic [DIV_W-1:0]   sck_hi_div,
   input  logic               miso,
   output logic               tgt_rst_n,
   output logic               sck,
   output logic               mosi,
   output logic               done,
   output logic               fail
);
   import isp_pkg::*;

   localparam int unsigned SETTLE_CYC =
      32'((64'(CLK_HZ) * 64'(SETTLE_US)) / 64'd1_000_000);
   localparam int unsigned TMR_MAX = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
   localparam int          TMR_W   = $clog2(TMR_MAX + 1);
   localparam int          RW1     = RETRY_W + 1;

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("settle interval must be at least one clock");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("reset pulse must be at least one clock");
      end
      if (DIV_W < 1 || RETRY_W < 1) begin : g_bad_width
         $error("divider and retry widths must be positive");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic [1:0]       idx_q;
   logic [RETRY_W-1:0] tries_q;
   logic [7:0]       echo_q;
   logic             rst_q;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_done;
   logic             go;
   logic             fin;
   logic [7:0]       rx_byte;
   logic             idle_like;
   logic             start_acc;
   logic [RW1-1:0]   tries_nx;

   assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
   assign start_acc = start && idle_like;
   assign tries_nx  = {1'b0, tries_q} + RW1'(1);

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      go       = 1'b0;
      case (state_q)
         ST_IDLE, ST_DONE, ST_FAIL: begin
            if (start) begin
               state_d  = ST_SETTLE;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(SETTLE_CYC - 1);
            end
         end
         ST_SETTLE: if (tmr_done) state_d = ST_LOAD;
         ST_LOAD: begin
            go      = 1'b1;
            state_d = ST_XFER;
         end
         ST_XFER: begin
            if (fin) begin
               if (idx_q != LAST_SLOT)
                  state_d = ST_LOAD;
               else if (echo_q == SYNC_BYTE)
                  state_d = ST_DONE;
               else if (tries_nx >= {1'b0, max_tries})
                  state_d = ST_FAIL;
               else begin
                  state_d  = ST_PULSE;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(PULSE_CYC - 1);
               end
            end
         end
         ST_PULSE: begin
            if (tmr_done) begin
               state_d  = ST_SETTLE;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(SETTLE_CYC - 1);
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         tries_q <= '0;
         echo_q  <= '0;
         rst_q   <= 1'b1;
      end else begin
         state_q <= state_d;
         rst_q   <= !((state_d == ST_SETTLE) || (state_d == ST_LOAD) ||
                      (state_d == ST_XFER)   || (state_d == ST_DONE));
         if (start_acc)
            tries_q <= '0;
         else if (state_d == ST_PULSE && state_q == ST_XFER)
            tries_q <= tries_nx[RETRY_W-1:0];
         if (state_d == ST_SETTLE)
            idx_q <= '0;
         else if (state_q == ST_XFER && fin)
            idx_q <= idx_q + 2'd1;
         if (state_q == ST_XFER && fin && idx_q == ECHO_SLOT)
            echo_q <= rx_byte;
      end
   end

   isp_tick_timer #(.W(TMR_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .ld_val  (tmr_val),
      .expired (tmr_done)
   );

   isp_spi_shift #(.DIV_W(DIV_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .tx_byte (frame_byte(idx_q)),
      .lo_div  (sck_lo_div),
      .hi_div  (sck_hi_div),
      .miso    (miso),
      .sck     (sck),
      .mosi    (mosi),
      .rx_byte (rx_byte),
      .fin     (fin)
   );

   assign tgt_rst_n = rst_q;
   assign done      = (state_q == ST_DONE);
   assign fail      = (state_q == ST_FAIL);

endmodule

// File: rtl/isp_entry_seq_chk.sv
module isp_entry_seq_chk #(
   parameter int unsigned SETTLE_CYC = 1
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic tgt_rst_n,
   input logic sck,
   input logic mosi,
   input logic done,
   input logic fail
);

   logic [31:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_cnt <= '0;
      else if (tgt_rst_n)
         low_cnt <= '0;
      else if (low_cnt != '1)
         low_cnt <= low_cnt + 32'd1;
   end

   AST_SCK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> !tgt_rst_n);                                        // R2
   AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> (low_cnt >= SETTLE_CYC));                    // R2
   AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));                     // R3
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!tgt_rst_n && !sck));                             // R6
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);                                 // R6
   AST_FAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (tgt_rst_n && !sck));                              // R9
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));                                           // R11

endmodule

bind isp_entry_seq isp_entry_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .tgt_rst_n (tgt_rst_n),
   .sck       (sck),
   .mosi      (mosi),
   .done      (done),
   .fail      (fail)
);

// File: tb/isp_entry_seq_tb.sv
module isp_entry_seq_tb;

   localparam int unsigned CLK_HZ    = 200_000_000;
   localparam int unsigned SETTLE_US = 1;
   localparam int unsigned SETTLE    = 200;
   localparam int unsigned PULSE     = 12;
   localparam int DIV_W   = 4;
   localparam int RETRY_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [RETRY_W-1:0] max_tries = '0;
   logic [DIV_W-1:0] lo_div = 4'd1;
   logic [DIV_W-1:0] hi_div = 4'd4;
   logic miso;
   logic tgt_rst_n, sck, mosi, done, fail;

   always #2.5 clk = ~clk;

   isp_entry_seq #(
      .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .PULSE_CYC(PULSE),
      .DIV_W(DIV_W), .RETRY_W(RETRY_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .max_tries(max_tries),
      .sck_lo_div(lo_div), .sck_hi_div(hi_div), .miso(miso),
      .tgt_rst_n(tgt_rst_n), .sck(sck), .mosi(mosi), .done(done), .fail(fail)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard: driver pushes the bytes the target must receive
   logic [7:0] exp_q[$];

   task automatic push_frames(input int n);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(8'hAC);
         exp_q.push_back(8'h53);
         exp_q.push_back(8'h00);
         exp_q.push_back(8'h00);
      end
   endtask

   // target model: echoes the previous byte, corrupts the sync echo on demand
   int tgt_bits = 0;
   int frames = 0;
   int bad_left = 0;
   logic [7:0] rx_sh = '0;
   logic [7:0] prev_rx = '0;
   logic [7:0] reply;

   always @* begin
      if ((tgt_bits / 8) % 4 == 0)
         reply = 8'h00;
      else if ((tgt_bits / 8) % 4 == 2 && bad_left > 0)
         reply = 8'hA5;
      else
         reply = prev_rx;
      miso = reply[7 - (tgt_bits % 8)];
   end

   always @(posedge sck) begin
      logic [7:0] b;
      b = {rx_sh[6:0], mosi};
      rx_sh = b;
      tgt_bits++;
      if (tgt_bits % 8 == 0) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 extra byte", b, 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(b == e, "R3 frame byte", b, e);
         end
         prev_rx = b;
         if (tgt_bits % 32 == 0) begin
            frames++;
            if (bad_left > 0) bad_left--;
         end
      end
   end

   // timing monitor, sampled away from the active edge
   int mon_bit = 0;
   int hi_run = 0, lo_run = 0, rst_low_run = 0, rst_hi_run = 0;
   logic prev_sck = 1'b0, prev_rst = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (sck && tgt_rst_n) chk(1'b0, "R2 sck high while target reset released", 1, 0);
         if (sck && !prev_sck) begin
            if (mon_bit % 8 != 0)
               chk(lo_run == int'(lo_div) + 1, "R4 low phase", lo_run, int'(lo_div) + 1);
            if (mon_bit % 32 == 0)
               chk(rst_low_run >= int'(SETTLE), "R2 settle before first edge", rst_low_run, SETTLE);
            mon_bit++;
            hi_run = 1;
         end else if (sck) begin
            hi_run++;
         end else if (prev_sck) begin
            chk(hi_run == int'(hi_div) + 1, "R4 high phase", hi_run, int'(hi_div) + 1);
            lo_run = 1;
         end else begin
            lo_run++;
         end
         if (!tgt_rst_n && prev_rst && mon_bit > 0)
            chk(rst_hi_run == int'(PULSE), "R7 reset pulse width", rst_hi_run, PULSE);
         if (tgt_rst_n) begin rst_hi_run++; rst_low_run = 0; end
         else begin rst_low_run++; rst_hi_run = 0; end
      end
      prev_sck = sck;
      prev_rst = tgt_rst_n;
   end

   task automatic run(input int bad, input int maxt, input int lo, input int hi,
                      input bit exp_done, input int exp_frames, input int extra_at,
                      output int dur);
      @(negedge clk);
      lo_div = DIV_W'(lo);
      hi_div = DIV_W'(hi);
      max_tries = RETRY_W'(maxt);
      bad_left = bad;
      mon_bit = 0;
      tgt_bits = 0;
      frames = 0;
      push_frames(exp_frames);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!done && !fail, "R11 flags clear after start", {done, fail}, 0);
      chk(!tgt_rst_n, "R2 reset asserted after start", tgt_rst_n, 0);
      dur = 1;
      while (!(done || fail) && dur < 20000) begin
         if (dur == extra_at) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         dur++;
      end
      chk(done == exp_done, exp_done ? "R6 done raised" : "R9 no done on exhaustion", done, exp_done);
      chk(fail == !exp_done, exp_done ? "R11 no fail on success" : "R9 fail raised", fail, !exp_done);
      chk(frames == exp_frames, "R8 full frames per attempt", frames, exp_frames);
      chk(exp_q.size() == 0, "R3 all expected bytes seen", exp_q.size(), 0);
      if (exp_done) chk(!tgt_rst_n && !sck, "R6 target kept in reset", {tgt_rst_n, sck}, 0);
      else chk(tgt_rst_n && !sck, "R9 target released", {tgt_rst_n, sck}, 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int dur_a, dur_x, held;
      repeat (3) @(negedge clk);
      chk(tgt_rst_n && !sck && !mosi && !done && !fail, "R1 reset state",
          {tgt_rst_n, sck, mosi, done, fail}, 5'b10000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5 R6: first attempt synchronised
      run(0, 3, 1, 4, 1'b1, 1, 0, dur_a);
      held = mon_bit;
      repeat (40) @(negedge clk);
      chk(done && !tgt_rst_n && mon_bit == held, "R6 done state held", {done, tgt_rst_n}, 2'b10);

      // R5 R7: two corrupted echoes then success
      run(2, 3, 1, 4, 1'b1, 3, 0, dur_x);

      // R9: all attempts corrupted
      run(5, 3, 1, 4, 1'b0, 3, 0, dur_x);
      held = mon_bit;
      repeat (60) @(negedge clk);
      chk(fail && tgt_rst_n && mon_bit == held, "R9 idle after fail", mon_bit, held);

      // R9: limit of zero acts as one attempt
      run(1, 0, 1, 4, 1'b0, 1, 0, dur_x);

      // R4: other divider setting
      run(0, 1, 3, 2, 1'b1, 1, 0, dur_x);

      // R10: start during settle is ignored
      run(0, 3, 1, 4, 1'b1, 1, 50, dur_x);
      chk(dur_x == dur_a, "R10 busy start ignored", dur_x, dur_a);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule